// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a register file and a byte-addressed data memory port. It takes one access request at a time and forms the effective address from a base register. The offset is either a second register or a signed 13-bit immediate. It then checks that the address is naturally aligned for the access size and drives a single word-wide memory beat with per-byte enables. Memory is big-endian: byte offset 0 of a word occupies bits 31:24.

On loads, the addressed byte or halfword is moved to the low bits of the result, and the upper bits are filled with zeros or with copies of the value's top bit. The result is written back to the register file one cycle after the memory beat. On stores, the low byte or halfword of the source value is copied onto every lane, and the enables select the lanes that are written.

A doubleword access takes two consecutive beats and uses an even/odd register pair. The even register maps to the lower address, which holds the more significant word. The unit refuses a new request while the second beat is in flight. A misaligned access, or a doubleword access that names an odd register, produces no memory beat and no register write. Instead the unit raises a fault pulse in the following cycle.

Top module: `mem_lane_aligner`

## Requirements
- R1: When `imm_sel` is 0, the effective address is `rs1_val + rs2_val`, and `mem_addr` carries it with its two low bits cleared.
- R2: When `imm_sel` is 1, the effective address is `rs1_val` plus `simm13` sign-extended from bit 12, so negative offsets subtract.
- R3: A byte load at offset k returns bits [31-8k -: 8] of `mem_rdata`, and a halfword load at offset 0 or 2 returns bits 31:16 or 15:0, placed in the low bits of `rf_wdata`.
- R4: When `req_signed` is 0, the bits above a loaded byte or halfword are zero. When it is 1, they copy the loaded value's top bit.
- R5: A load raises `rf_we` for exactly the cycle after its memory beat, with `rf_waddr` equal to the requested register. A word load returns `mem_rdata` unchanged.
- R6: A store drives `mem_we` = 1. Byte store enables are 1000, 0100, 0010 or 0001 for offsets 0 to 3, and halfword enables are 1100 or 0011. Word enables are 1111. `mem_wdata` repeats the low 8 or 16 bits of `st_data`, so the upper source bits never reach memory.
- R7: A doubleword access performs a beat at the effective address and then a beat at address + 4 in the next cycle, with `req_ready` low during that second beat. A doubleword load writes the first word to the even register and the second word to that register + 1.
- R8: A doubleword store writes `st_data` in the first beat and `st_data_odd` in the second beat, both with all four enables set.
- R9: Halfword accesses need address bit 0 clear, word accesses need bits 1:0 clear, and doubleword accesses need bits 2:0 clear. Byte accesses are accepted at any address.
- R10: A misaligned access, or a doubleword access with an odd `req_reg`, drives no `mem_req` and causes no `rf_we`. `fault` is 1 for exactly the cycle after the request.
- R11: During reset, `req_ready` is 1 and `mem_req`, `rf_we` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend a loaded byte/halfword |
| req_reg | input | 5 | Destination (load) or source (store) register number |
| rs1_val | input | 32 | Base register value |
| rs2_val | input | 32 | Index register value |
| imm_sel | input | 1 | Use the immediate instead of `rs2_val` |
| simm13 | input | 13 | Signed immediate offset |
| st_data | input | 32 | Store value (even register for doubleword) |
| st_data_odd | input | 32 | Store value of the odd register for doubleword |
| mem_req | output | 1 | Memory beat active |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_rdata | input | 32 | Read data for the current beat (same cycle) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write value |
| fault | output | 1 | Alignment/pairing fault pulse |

## Verification
The bench loads every byte offset, both signed and unsigned, from words whose bytes alternate in sign. A design with little-endian lanes or a wrong fill returns a neighbouring byte or the wrong upper bits. Byte and halfword stores use source values with non-zero upper bits, and each is followed by a read-back. Stray enables or unreplicated data would then corrupt adjacent bytes.

Doubleword tests watch both beats. A design that reuses the first address, or that forgets to force the odd register, would write to the wrong word or register. Misaligned requests for each size cover an aligned word that is not doubleword-aligned and an odd register pair. A design that still strobes memory, or that holds the fault longer than one cycle, is reported.

// File: rtl/mla_pkg.sv
package mla_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;
endpackage

// File: rtl/mla_ea_gen.sv
module mla_ea_gen #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 13
) (
   input  logic [XLEN-1:0]  base_i,
   input  logic [XLEN-1:0]  index_i,
   input  logic             use_imm_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic [XLEN-1:0]  ea_o
);
   localparam int EXT_W = XLEN - IMM_W;

   if (IMM_W < 2 || IMM_W >= XLEN) begin : g_bad_imm
      $error("mla_ea_gen: IMM_W must lie in [2, XLEN)");
   end

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] offset;

   assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign offset  = use_imm_i ? imm_ext : index_i;
   assign ea_o    = base_i + offset;
endmodule

// File: rtl/mla_align_chk.sv
module mla_align_chk
   import mla_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  logic [1:0]     size_i,
   input  logic [OFF_W:0] addr_lo_i,
   input  logic           reg_lsb_i,
   output logic           bad_o
);
   if (OFF_W < 2) begin : g_bad_off
      $error("mla_align_chk: OFF_W must be at least 2");
   end

   always_comb begin
      case (size_i)
         SZ_BYTE:  bad_o = 1'b0;
         SZ_HALF:  bad_o = addr_lo_i[0];
         SZ_WORD:  bad_o = |addr_lo_i[OFF_W-1:0];
         default:  bad_o = (|addr_lo_i) | reg_lsb_i;
      endcase
   end
endmodule

// File: rtl/mla_store_lanes.sv
module mla_store_lanes
   import mla_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [1:0]              size_i,
   input  logic [$clog2(XLEN/8)-1:0] off_i,
   input  logic [XLEN-1:0]         data_i,
   output logic [XLEN-1:0]         wdata_o,
   output logic [XLEN/8-1:0]       be_o
);
   localparam int LANES = XLEN / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int CNT_W = OFF_W + 1;

   if (XLEN % 16 != 0 || LANES != (1 << OFF_W)) begin : g_bad_xlen
      $error("mla_store_lanes: XLEN must be a power-of-two count of bytes");
   end

   logic [CNT_W-1:0] nbytes;
   logic [CNT_W-1:0] first;
   logic [CNT_W-1:0] last_ex;

   always_comb begin
      case (size_i)
         SZ_BYTE: begin
            nbytes  = CNT_W'(1);
            wdata_o = {LANES{data_i[7:0]}};
         end
         SZ_HALF: begin
            nbytes  = CNT_W'(2);
            wdata_o = {(LANES/2){data_i[15:0]}};
         end
         default: begin
            nbytes  = CNT_W'(LANES);
            wdata_o = data_i;
         end
      endcase
   end

   assign first   = {1'b0, off_i};
   assign last_ex = first + nbytes;

   // lane position p counts from the most significant byte (big-endian)
   for (genvar p = 0; p < LANES; p++) begin : g_lane
      assign be_o[LANES-1-p] = (first <= CNT_W'(p)) && (CNT_W'(p) < last_ex);
   end
endmodule

// File: rtl/mla_load_extract.sv
module mla_load_extract
   import mla_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [1:0]                size_i,
   input  logic [$clog2(XLEN/8)-1:0] off_i,
   input  logic                      signed_i,
   input  logic [XLEN-1:0]           rdata_i,
   output logic [XLEN-1:0]           value_o
);
   localparam int OFF_W = $clog2(XLEN/8);

   logic [XLEN-1:0] shifted;
   logic [7:0]      byte_v;
   logic [15:0]     half_v;
   logic            fill_b;
   logic            fill_h;

   assign shifted = rdata_i << {off_i, 3'b000};
   assign byte_v  = shifted[XLEN-1 -: 8];
   assign half_v  = shifted[XLEN-1 -: 16];
   assign fill_b  = signed_i & byte_v[7];
   assign fill_h  = signed_i & half_v[15];

   always_comb begin
      case (size_i)
         SZ_BYTE: value_o = {{(XLEN-8){fill_b}}, byte_v};
         SZ_HALF: value_o = {{(XLEN-16){fill_h}}, half_v};
         default: value_o = rdata_i;
      endcase
   end

   if (OFF_W + 3 > XLEN) begin : g_bad_shift
      $error("mla_load_extract: shift width exceeds XLEN");
   end
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
   import mla_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int IMM_W  = 13,
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic [REG_AW-1:0] req_reg,
   input  logic [XLEN-1:0]   rs1_val,
   input  logic [XLEN-1:0]   rs2_val,
   input  logic              imm_sel,
   input  logic [IMM_W-1:0]  simm13,
   input  logic [XLEN-1:0]   st_data,
   input  logic [XLEN-1:0]   st_data_odd,
   output logic              mem_req,
   output logic              mem_we,
   output logic [XLEN-1:0]   mem_addr,
   output logic [XLEN/8-1:0] mem_be,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_waddr,
   output logic [XLEN-1:0]   rf_wdata,
   output logic              fault
);
   localparam int LANES = XLEN / 8;
   localparam int OFF_W = $clog2(LANES);

   if (REG_AW < 1) begin : g_bad_reg
      $error("mem_lane_aligner: REG_AW must be positive");
   end

   // ---------------- address and alignment ----------------
   logic [XLEN-1:0] ea;
   logic            misal;

   mla_ea_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ea (
      .base_i   (rs1_val),
      .index_i  (rs2_val),
      .use_imm_i(imm_sel),
      .imm_i    (simm13),
      .ea_o     (ea)
   );

   mla_align_chk #(.OFF_W(OFF_W)) u_chk (
      .size_i   (req_size),
      .addr_lo_i(ea[OFF_W:0]),
      .reg_lsb_i(req_reg[0]),
      .bad_o    (misal)
   );

   // ---------------- second-beat state ----------------
   logic              busy_q;
   logic              b1_store_q;
   logic [XLEN-1:0]   b1_addr_q;
   logic [XLEN-1:0]   b1_data_q;
   logic [REG_AW-1:0] b1_reg_q;

   logic take;
   logic go;
   logic is_pair;

   assign req_ready = !busy_q;
   assign take      = req_valid && !busy_q;
   assign go        = take && !misal;
   assign is_pair   = (req_size == SZ_DWORD);

   // ---------------- current beat select ----------------
   logic [XLEN-1:0]   cur_addr;
   logic [XLEN-1:0]   cur_data;
   logic [1:0]        cur_size;
   logic              cur_store;
   logic              cur_signed;
   logic [REG_AW-1:0] cur_reg;

   always_comb begin
      if (busy_q) begin
         cur_addr   = b1_addr_q;
         cur_data   = b1_data_q;
         cur_size   = SZ_WORD;
         cur_store  = b1_store_q;
         cur_signed = 1'b0;
         cur_reg    = b1_reg_q;
      end else begin
         cur_addr   = ea;
         cur_data   = st_data;
         cur_size   = is_pair ? SZ_WORD : req_size;
         cur_store  = req_store;
         cur_signed = req_signed;
         cur_reg    = req_reg;
      end
   end

   assign mem_req  = busy_q | go;
   assign mem_we   = cur_store;
   assign mem_addr = {cur_addr[XLEN-1:OFF_W], {OFF_W{1'b0}}};

   mla_store_lanes #(.XLEN(XLEN)) u_st (
      .size_i (cur_size),
      .off_i  (cur_addr[OFF_W-1:0]),
      .data_i (cur_data),
      .wdata_o(mem_wdata),
      .be_o   (mem_be)
   );

   logic [XLEN-1:0] ld_val;

   mla_load_extract #(.XLEN(XLEN)) u_ld (
      .size_i  (cur_size),
      .off_i   (cur_addr[OFF_W-1:0]),
      .signed_i(cur_signed),
      .rdata_i (mem_rdata),
      .value_o (ld_val)
   );

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         b1_store_q <= 1'b0;
         b1_addr_q  <= '0;
         b1_data_q  <= '0;
         b1_reg_q   <= '0;
         rf_we      <= 1'b0;
         rf_waddr   <= '0;
         rf_wdata   <= '0;
         fault      <= 1'b0;
      end else begin
         fault    <= take && misal;
         rf_we    <= mem_req && !cur_store;
         rf_waddr <= cur_reg;
         rf_wdata <= ld_val;
         if (busy_q) begin
            busy_q <= 1'b0;
         end else if (go && is_pair) begin
            busy_q     <= 1'b1;
            b1_addr_q  <= ea + XLEN'(LANES);
            b1_data_q  <= st_data_odd;
            b1_store_q <= req_store;
            b1_reg_q   <= {req_reg[REG_AW-1:1], 1'b1};
         end
      end
   end

   // ---------------- assertions ----------------
   // R10
   fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !rf_we);
   // R10
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(req_valid && req_ready && !mem_req));
   // R7
   pair_one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);
   // R7
   pair_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> mem_addr == $past(mem_addr) + XLEN'(LANES));
   // R7
   pair_odd_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && $past(!req_ready)) |-> rf_waddr[0]);
   // R5
   wb_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(mem_req && !mem_we));
   // R6
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && req_ready && req_size == SZ_BYTE) |-> $countones(mem_be) == 1);
endmodule

// File: tb/mem_lane_aligner_bench.sv
module mem_lane_aligner_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_store, req_signed, imm_sel;
   logic [1:0]  req_size;
   logic [4:0]  req_reg;
   logic [31:0] rs1_val, rs2_val, st_data, st_data_odd;
   logic [12:0] simm13;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic        rf_we, fault;
   logic [4:0]  rf_waddr;
   logic [31:0] rf_wdata;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mem_lane_aligner u_mem_lane_aligner (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_store(req_store), .req_size(req_size), .req_signed(req_signed),
      .req_reg(req_reg), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_sel(imm_sel),
      .simm13(simm13), .st_data(st_data), .st_data_odd(st_data_odd),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .fault(fault)
   );

   // ---------------- memory model ----------------
   logic [31:0] mem [16];
   logic [31:0] ref_mem [16];

   function automatic logic [31:0] init_word(int i);
      return {8'(8'h80 + i), 8'(8'h10 + i), 8'(8'hC0 + i), 8'(8'h20 + i)};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      end else if (mem_req && mem_we) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
   end

   assign mem_rdata = mem[mem_addr[5:2]];

   // ---------------- captures ----------------
   logic        m0_req, m0_we;
   logic [31:0] m0_addr, m0_wd;
   logic [3:0]  m0_be;
   logic        n1_we, n1_fault, n1_ready, n1_mreq;
   logic [4:0]  n1_wa;
   logic [31:0] n1_wd, n1_maddr, n1_mwd;
   logic [3:0]  n1_mbe;
   logic        n2_we, n2_fault;
   logic [4:0]  n2_wa;
   logic [31:0] n2_wd;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(logic st, logic [1:0] sz, logic sgn, logic [4:0] rg,
                        logic [31:0] a, logic [31:0] b, logic isel, logic [12:0] imm,
                        logic [31:0] d, logic [31:0] dodd);
      @(negedge clk);
      req_store = st; req_size = sz; req_signed = sgn; req_reg = rg;
      rs1_val = a; rs2_val = b; imm_sel = isel; simm13 = imm;
      st_data = d; st_data_odd = dodd; req_valid = 1'b1;
      #1;
      m0_req = mem_req; m0_we = mem_we; m0_addr = mem_addr; m0_be = mem_be; m0_wd = mem_wdata;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      n1_we = rf_we; n1_wa = rf_waddr; n1_wd = rf_wdata; n1_fault = fault;
      n1_ready = req_ready; n1_mreq = mem_req; n1_maddr = mem_addr;
      n1_mwd = mem_wdata; n1_mbe = mem_be;
      @(posedge clk);
      @(negedge clk);
      n2_we = rf_we; n2_wa = rf_waddr; n2_wd = rf_wdata; n2_fault = fault;
   endtask

   function automatic logic [31:0] exp_load(logic [31:0] w, int off, logic [1:0] sz, logic sgn);
      logic [7:0]  bv;
      logic [15:0] hv;
      bv = w[31-8*off -: 8];
      hv = (off == 0) ? w[31:16] : w[15:0];
      if (sz == 2'd0) return {{24{sgn & bv[7]}}, bv};
      if (sz == 2'd1) return {{16{sgn & hv[15]}}, hv};
      return w;
   endfunction

   task automatic readback(string req, int idx);
      issue(1'b0, 2'd2, 1'b0, 5'd1, 32'(idx * 4), 32'd0, 1'b0, 13'd0, 32'd0, 32'd0);
      chk(req, "readback word", n1_wd, ref_mem[idx]);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      // R11
      chk("R11", "ready in reset", 32'(req_ready), 32'd1);
      chk("R11", "mem_req in reset", 32'(mem_req), 32'd0);
      chk("R11", "rf_we in reset", 32'(rf_we), 32'd0);
      chk("R11", "fault in reset", 32'(fault), 32'd0);
   endtask

   task automatic t_ea_reg();
      // R1, R5
      issue(1'b0, 2'd2, 1'b0, 5'd9, 32'h10, 32'h08, 1'b0, 13'h1FFF, 32'd0, 32'd0);
      chk("R1", "reg+reg addr", m0_addr, 32'h18);
      chk("R5", "word load data", n1_wd, ref_mem[6]);
      chk("R5", "word load we", 32'(n1_we), 32'd1);
      chk("R5", "word load waddr", 32'(n1_wa), 32'd9);
      chk("R5", "we drops after one cycle", 32'(n2_we), 32'd0);
      // R1 unaligned sum: byte at 0x13 -> word 0x10
      issue(1'b0, 2'd0, 1'b0, 5'd2, 32'h11, 32'h02, 1'b0, 13'd0, 32'd0, 32'd0);
      chk("R1", "reg+reg byte addr", m0_addr, 32'h10);
   endtask

   task automatic t_ea_imm();
      // R2: 0x30 + (-8) = 0x28
      issue(1'b0, 2'd2, 1'b0, 5'd3, 32'h30, 32'h4, 1'b1, 13'h1FF8, 32'd0, 32'd0);
      chk("R2", "imm negative addr", m0_addr, 32'h28);
      chk("R2", "imm negative data", n1_wd, ref_mem[10]);
      // R2: 0x4 + 0x0C = 0x10
      issue(1'b0, 2'd2, 1'b0, 5'd3, 32'h4, 32'h100, 1'b1, 13'h000C, 32'd0, 32'd0);
      chk("R2", "imm positive addr", m0_addr, 32'h10);
   endtask

   task automatic t_load_sub();
      for (int off = 0; off < 4; off++) begin
         for (int s = 0; s < 2; s++) begin
            issue(1'b0, 2'd0, 1'(s), 5'd7, 32'h14, 32'(off), 1'b0, 13'd0, 32'd0, 32'd0);
            // R3, R4, R9 byte at any offset
            chk(s ? "R4" : "R3", "byte load", n1_wd, exp_load(ref_mem[5], off, 2'd0, 1'(s)));
            chk("R9", "byte any offset no fault", 32'(n1_fault), 32'd0);
         end
      end
      for (int off = 0; off < 4; off += 2) begin
         for (int s = 0; s < 2; s++) begin
            issue(1'b0, 2'd1, 1'(s), 5'd8, 32'h1C, 32'(off), 1'b0, 13'd0, 32'd0, 32'd0);
            chk(s ? "R4" : "R3", "half load", n1_wd, exp_load(ref_mem[7], off, 2'd1, 1'(s)));
         end
      end
   endtask

   task automatic t_store_sub();
      for (int off = 0; off < 4; off++) begin
         logic [7:0] bv;
         bv = 8'(8'h51 + off);
         issue(1'b1, 2'd0, 1'b0, 5'd4, 32'h04, 32'(off), 1'b0, 13'd0, {24'hABCDEF, bv}, 32'd0);
         // R6
         chk("R6", "byte store be", 32'(m0_be), 32'(4'b1000 >> off));
         chk("R6", "byte store wdata", m0_wd, {4{bv}});
         chk("R6", "byte store we", 32'({m0_req, m0_we}), 32'd3);
         ref_mem[1][31-8*off -: 8] = bv;
         readback("R6", 1);
      end
      for (int off = 0; off < 4; off += 2) begin
         issue(1'b1, 2'd1, 1'b0, 5'd4, 32'h08, 32'(off), 1'b0, 13'd0, 32'hDEAD0000 | 32'(16'h7E00 + off), 32'd0);
         chk("R6", "half store be", 32'(m0_be), (off == 0) ? 32'hC : 32'h3);
         chk("R6", "half store wdata", m0_wd, {2{16'(16'h7E00 + off)}});
         if (off == 0) ref_mem[2][31:16] = 16'h7E00; else ref_mem[2][15:0] = 16'(16'h7E00 + off);
         readback("R6", 2);
      end
   endtask

   task automatic t_pair_load();
      // R7
      issue(1'b0, 2'd3, 1'b1, 5'd4, 32'h20, 32'd0, 1'b0, 13'd0, 32'd0, 32'd0);
      chk("R7", "beat0 addr", m0_addr, 32'h20);
      chk("R7", "beat1 addr", n1_maddr, 32'h24);
      chk("R7", "beat1 mem_req", 32'(n1_mreq), 32'd1);
      chk("R7", "ready low in beat1", 32'(n1_ready), 32'd0);
      chk("R7", "even reg data", n1_wd, ref_mem[8]);
      chk("R7", "even reg index", 32'(n1_wa), 32'd4);
      chk("R7", "odd reg data", n2_wd, ref_mem[9]);
      chk("R7", "odd reg index", 32'(n2_wa), 32'd5);
      chk("R7", "odd reg we", 32'(n2_we), 32'd1);
   endtask

   task automatic t_pair_store();
      // R8
      issue(1'b1, 2'd3, 1'b0, 5'd6, 32'h2C, 32'h4, 1'b0, 13'd0, 32'h12345678, 32'h9ABCDEF0);
      chk("R8", "beat0 be", 32'(m0_be), 32'hF);
      chk("R8", "beat0 wdata", m0_wd, 32'h12345678);
      chk("R8", "beat1 addr", n1_maddr, 32'h34);
      chk("R8", "beat1 wdata", n1_mwd, 32'h9ABCDEF0);
      chk("R8", "beat1 be", 32'(n1_mbe), 32'hF);
      chk("R8", "no reg write on store", 32'(n1_we | n2_we), 32'd0);
      ref_mem[12] = 32'h12345678;
      ref_mem[13] = 32'h9ABCDEF0;
      readback("R8", 12);
      readback("R8", 13);
   endtask

   task automatic t_misalign(string what, logic [1:0] sz, logic st, logic [4:0] rg, logic [31:0] a);
      // R9, R10
      issue(st, sz, 1'b0, rg, a, 32'd0, 1'b0, 13'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
      chk("R10", {what, " mem_req"}, 32'(m0_req), 32'd0);
      chk("R10", {what, " fault pulse"}, 32'(n1_fault), 32'd1);
      chk("R10", {what, " no reg write"}, 32'(n1_we), 32'd0);
      chk("R10", {what, " fault clears"}, 32'(n2_fault), 32'd0);
      chk("R9", {what, " no second beat"}, 32'(n1_mreq), 32'd0);
   endtask

   // ---------------- main ----------------
   initial begin
      for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
      rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
      req_signed = 1'b0; req_reg = 5'd0; rs1_val = 32'd0; rs2_val = 32'd0;
      imm_sel = 1'b0; simm13 = 13'd0; st_data = 32'd0; st_data_odd = 32'd0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_ea_reg();
      t_ea_imm();
      t_load_sub();
      t_store_sub();
      t_pair_load();
      t_pair_store();
      t_misalign("half odd", 2'd1, 1'b0, 5'd2, 32'h21);
      t_misalign("word off2", 2'd2, 1'b1, 5'd2, 32'h22);
      t_misalign("dword off4", 2'd3, 1'b0, 5'd2, 32'h24);
      t_misalign("dword odd reg", 2'd3, 1'b1, 5'd3, 32'h28);
      readback("R10", 10);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule